// File: doc/BRIEF.md
# Dual Parallel Port Interface

This block gives a host 48 general-purpose I/O lines through a byte-wide synchronous register bus. The lines are organised as two identical groups. Each group has three 8-bit data ports, here called A, B and C, and one control register. The host reaches all eight registers through a 3-bit address, with separate read and write strobes. On the pin side every line has an output value, an output enable and an input sample.

Each group works only in basic latched mode. Data-port writes load an output latch. Data-port reads return the synchronised pin level of every input line and the latched value of every output line. A control write with bit 7 set is a mode word. It sets the direction of port A as a whole, the direction of port B as a whole, and the direction of each nibble of port C. A control write with bit 7 clear sets or clears a single bit of port C.

Top module: `dual_pio`

## Requirements
- R1: After reset, every output enable is 0, every output value is 0, and all four direction settings of both groups are input. A read of a data port therefore returns the synchronised pin levels.
- R2: Address decode:
  - Offsets 0, 1 and 2 are ports A, B and C of group 0, and offset 3 is the group 0 control register.
  - Offsets 4 to 7 are the same four registers for group 1.
  - Pin index = group*24 + port*8 + bit, where port A is 0, B is 1 and C is 2.
- R3: In a mode word (bit 7 = 1), bit 4 sets the direction of all of port A and bit 1 sets the direction of all of port B. A 1 means input and a 0 means output. The output enable of a line is the inverse of its input setting. It changes on the clock edge that accepts the write.
- R4: In a mode word, bit 3 sets the direction of port C lines 7:4 and bit 0 sets the direction of port C lines 3:0. A 1 means input.
- R5: Every mode word clears the output latches of ports A, B and C of its own group.
- R6: Bits 6, 5 and 2 of a mode word have no effect. Two mode words that differ only in those bits give the same directions.
- R7: A write to a data port loads that port's output latch. The latch drives the port's output values from the next clock edge on.
- R8: A control write with bit 7 = 0 is a single-bit command. Bits 3:1 select a bit of the group's port C latch, and bit 0 is the new value. All other latch bits and all directions are left unchanged.
- R9: Data-port read value:
  - Each input bit returns its pin level after a two-flop synchroniser. Each output bit returns its latch value.
  - The read value is registered on the clock edge where the read strobe is high.
  - It holds until the next read.
- R10: A read from a control offset (3 or 7) returns 0x00.
- R11: A write to one group leaves the other group's latches and directions unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |
| pin_out | output | 48 | Output value for each line |
| pin_oe | output | 48 | Output enable for each line, 1 drives the pin |
| pin_in | input | 48 | Asynchronous input sample for each line |

## Verification
A write is accepted on one rising edge. Its effect on the latches, on pin_out and on pin_oe is visible right after that edge, so the bench samples those outputs at the following falling edge. A read is captured on the rising edge where rd_en is high, and the bench samples rdata at the falling edge after it. A change on pin_in needs two rising edges to cross the synchroniser. The bench therefore waits three full cycles after changing the pins before it issues a read, and it rechecks rdata after a later pin change to confirm that the read value holds.

// File: rtl/dual_pio_pkg.sv
package dual_pio_pkg;

   localparam int unsigned SLOTS_PER_GRP = 4;
   localparam int unsigned PORTS_PER_GRP = 3;

   // control word bit positions (decoded by this block)
   localparam int unsigned MODE_FLAG_BIT = 7;
   localparam int unsigned A_DIR_BIT     = 4;
   localparam int unsigned CU_DIR_BIT    = 3;
   localparam int unsigned B_DIR_BIT     = 1;
   localparam int unsigned CL_DIR_BIT    = 0;

   typedef enum logic [1:0] {
      SLOT_A    = 2'd0,
      SLOT_B    = 2'd1,
      SLOT_C    = 2'd2,
      SLOT_CTRL = 2'd3
   } slot_e;

   // 1 = input
   typedef struct packed {
      logic a_in;
      logic b_in;
      logic cu_in;
      logic cl_in;
   } dir_t;

   localparam dir_t DIR_ALL_IN = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int unsigned WIDTH  = 48,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pio_group.sv
module pio_group
   import dual_pio_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned HALF_W = DATA_W / 2,
   localparam int unsigned GRP_W  = PORTS_PER_GRP * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  slot_e             slot,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [GRP_W-1:0]  pin_sync,
   output logic [GRP_W-1:0]  grp_out,
   output logic [GRP_W-1:0]  grp_oe,
   output logic [DATA_W-1:0] rd_val
);

   if (DATA_W != 8) begin : g_bad_width
      $error("pio_group: control word layout needs DATA_W of 8");
   end

   dir_t              dir_q;
   logic [DATA_W-1:0] lat_a, lat_b, lat_c;
   logic              grp_wr, ctrl_wr;
   logic              unused_mode_bits;

   assign grp_wr           = sel && wr_en;
   assign ctrl_wr          = grp_wr && (slot == SLOT_CTRL);
   assign unused_mode_bits = ^wdata[6:5];

   // direction register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= DIR_ALL_IN;
      end else if (ctrl_wr && wdata[MODE_FLAG_BIT]) begin
         dir_q.a_in  <= wdata[A_DIR_BIT];
         dir_q.b_in  <= wdata[B_DIR_BIT];
         dir_q.cu_in <= wdata[CU_DIR_BIT];
         dir_q.cl_in <= wdata[CL_DIR_BIT];
      end
   end

   // output latches
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_a <= '0;
         lat_b <= '0;
         lat_c <= '0;
      end else if (grp_wr) begin
         unique case (slot)
            SLOT_A: lat_a <= wdata;
            SLOT_B: lat_b <= wdata;
            SLOT_C: lat_c <= wdata;
            SLOT_CTRL: begin
               if (wdata[MODE_FLAG_BIT]) begin
                  lat_a <= '0;
                  lat_b <= '0;
                  lat_c <= '0;
               end else begin
                  lat_c[wdata[3:1]] <= wdata[0];
               end
            end
            default: ;
         endcase
      end
   end

   // output enables
   logic [DATA_W-1:0] oe_a, oe_b, oe_c;
   assign oe_a = {DATA_W{~dir_q.a_in}};
   assign oe_b = {DATA_W{~dir_q.b_in}};
   assign oe_c = {{HALF_W{~dir_q.cu_in}}, {HALF_W{~dir_q.cl_in}}};

   assign grp_out = {lat_c, lat_b, lat_a};
   assign grp_oe  = {oe_c, oe_b, oe_a};

   // read mux: output bits read back the latch, input bits the pin
   logic [DATA_W-1:0] mix_a, mix_b, mix_c;
   assign mix_a = (pin_sync[0*DATA_W +: DATA_W] & ~oe_a) | (lat_a & oe_a);
   assign mix_b = (pin_sync[1*DATA_W +: DATA_W] & ~oe_b) | (lat_b & oe_b);
   assign mix_c = (pin_sync[2*DATA_W +: DATA_W] & ~oe_c) | (lat_c & oe_c);

   always_comb begin
      unique case (slot)
         SLOT_A:  rd_val = mix_a;
         SLOT_B:  rd_val = mix_b;
         SLOT_C:  rd_val = mix_c;
         default: rd_val = '0;
      endcase
   end

   // R5: a mode word empties every latch of this group
   a_r5_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wdata[MODE_FLAG_BIT]) |=> (lat_a == '0 && lat_b == '0 && lat_c == '0));

   // R8: single-bit command lands on the chosen bit
   a_r8_bit_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !wdata[MODE_FLAG_BIT]) |=> (lat_c[$past(wdata[3:1])] == $past(wdata[0])));

   // R8: single-bit command keeps directions
   a_r8_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !wdata[MODE_FLAG_BIT]) |=> $stable(dir_q));

   // R7: data write loads the latch
   a_r7_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_wr && slot == SLOT_B) |=> (lat_b == $past(wdata)));

   // R11: no write to this group leaves it untouched
   a_r11_idle_group: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_wr |=> ($stable(lat_a) && $stable(lat_b) && $stable(lat_c) && $stable(dir_q)));

endmodule

// File: rtl/dual_pio.sv
module dual_pio
   import dual_pio_pkg::*;
#(
   parameter int unsigned N_GROUPS    = 2,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned ADDR_W = $clog2(N_GROUPS) + 2,
   localparam int unsigned GRP_W  = PORTS_PER_GRP * DATA_W,
   localparam int unsigned N_LINES = N_GROUPS * GRP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               rd_en,
   output logic [DATA_W-1:0]  rdata,
   output logic [N_LINES-1:0] pin_out,
   output logic [N_LINES-1:0] pin_oe,
   input  logic [N_LINES-1:0] pin_in
);

   if (N_GROUPS < 2) begin : g_bad_groups
      $error("dual_pio: N_GROUPS must be at least 2");
   end
   if (DATA_W != 8) begin : g_bad_width
      $error("dual_pio: DATA_W must be 8");
   end

   localparam int unsigned GSEL_W = ADDR_W - 2;

   logic [N_LINES-1:0] pin_sync;
   logic [DATA_W-1:0]  rd_vals [N_GROUPS];
   logic [GSEL_W-1:0]  grp_idx;
   slot_e              slot;

   assign grp_idx = addr[ADDR_W-1:2];
   assign slot    = slot_e'(addr[1:0]);

   pio_sync #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      logic sel;
      assign sel = (grp_idx == GSEL_W'(g));

      pio_group #(
         .DATA_W (DATA_W)
      ) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (sel),
         .slot     (slot),
         .wr_en    (wr_en),
         .wdata    (wdata),
         .pin_sync (pin_sync[g*GRP_W +: GRP_W]),
         .grp_out  (pin_out[g*GRP_W +: GRP_W]),
         .grp_oe   (pin_oe[g*GRP_W +: GRP_W]),
         .rd_val   (rd_vals[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_vals[grp_idx];
   end

   // R10: control offsets read as zero
   a_r10_ctrl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr[1:0] == 2'b11) |=> (rdata == '0));

   // R9: read data holds between reads
   a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

endmodule

// File: tb/dual_pio_test.sv
module dual_pio_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  addr;
   logic        wr_en;
   logic [7:0]  wdata;
   logic        rd_en;
   logic [7:0]  rdata;
   logic [47:0] pin_out;
   logic [47:0] pin_oe;
   logic [47:0] pin_in;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dual_pio uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wdata   (wdata),
      .rd_en   (rd_en),
      .rdata   (rdata),
      .pin_out (pin_out),
      .pin_oe  (pin_oe),
      .pin_in  (pin_in)
   );

   task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 oe after reset", pin_oe, 48'h0);
      chk("R1 out after reset", pin_out, 48'h0);
      rd(3'd0, v);
      chk("R1 read inputs port A grp0", {40'h0, v}, 48'h0000000000A7);
      rd(3'd6, v);
      chk("R1 read inputs port C grp1", {40'h0, v}, 48'h00000000003C);
   endtask

   task automatic t_mode_ab();
      wr(3'd3, 8'h80);
      chk("R3 grp0 all outputs", pin_oe, 48'h000000FFFFFF);
      wr(3'd7, 8'h92);
      chk("R3 grp1 A,B in C out", pin_oe, 48'hFF0000FFFFFF);
      wr(3'd7, 8'h82);
      chk("R3 grp1 B in", pin_oe, 48'hFF00FFFFFFFF);
   endtask

   task automatic t_mode_c();
      wr(3'd7, 8'h89);
      chk("R4 grp1 C both in", pin_oe, 48'h00FFFFFFFFFF);
      wr(3'd7, 8'h88);
      chk("R4 grp1 C upper in", pin_oe, 48'h0FFFFFFFFFFF);
      wr(3'd7, 8'h81);
      chk("R4 grp1 C lower in", pin_oe, 48'hF0FFFFFFFFFF);
   endtask

   task automatic t_ignored_bits();
      wr(3'd7, 8'hE4);
      chk("R6 E4 same as 80", pin_oe, 48'hFFFFFFFFFFFF);
      wr(3'd7, 8'hFF);
      chk("R6 FF same as 9B", pin_oe, 48'h000000FFFFFF);
   endtask

   task automatic t_data_write();
      logic [7:0] v;
      wr(3'd0, 8'h5A);
      wr(3'd1, 8'h3C);
      wr(3'd2, 8'hC3);
      chk("R7 grp0 latches on pins", pin_out, 48'h000000C33C5A);
      rd(3'd1, v);
      chk("R9 output bits read latch", {40'h0, v}, 48'h3C);
      wr(3'd3, 8'h80);
      chk("R5 mode word clears grp0", pin_out, 48'h0);
   endtask

   task automatic t_map();
      wr(3'd7, 8'h80);
      wr(3'd4, 8'h11);
      wr(3'd5, 8'h22);
      wr(3'd6, 8'h33);
      chk("R2 grp1 offsets 4..6", pin_out, 48'h332211000000);
      wr(3'd0, 8'h44);
      chk("R11 grp0 write keeps grp1", pin_out, 48'h332211000044);
      wr(3'd3, 8'h80);
      chk("R11 grp0 mode keeps grp1", pin_out, 48'h332211000000);
   endtask

   task automatic t_bit_cmd();
      wr(3'd3, 8'h0B);
      chk("R8 set bit5", pin_out[23:16], 48'h20);
      wr(3'd3, 8'h07);
      chk("R8 set bit3", pin_out[23:16], 48'h28);
      wr(3'd3, 8'h0A);
      chk("R8 clear bit5", pin_out[23:16], 48'h08);
      chk("R8 directions kept", pin_oe[23:0], 48'hFFFFFF);
   endtask

   task automatic t_read_mix();
      logic [7:0] v;
      wr(3'd7, 8'h88);
      wr(3'd6, 8'hA5);
      pin_in[47:40] = 8'h3C;
      settle();
      rd(3'd6, v);
      chk("R9 C upper pin lower latch", {40'h0, v}, 48'h35);
      pin_in[47:40] = 8'hC3;
      settle();
      chk("R9 rdata holds without read", {40'h0, rdata}, 48'h35);
      rd(3'd6, v);
      chk("R9 new pins after read", {40'h0, v}, 48'hC5);
      wr(3'd3, 8'h9B);
      pin_in[7:0] = 8'h77;
      settle();
      rd(3'd0, v);
      chk("R9 grp0 A as input", {40'h0, v}, 48'h77);
   endtask

   task automatic t_ctrl_read();
      logic [7:0] v;
      rd(3'd3, v);
      chk("R10 ctrl grp0 reads zero", {40'h0, v}, 48'h0);
      rd(3'd7, v);
      chk("R10 ctrl grp1 reads zero", {40'h0, v}, 48'h0);
   endtask

   initial begin
      rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0; rd_en = 1'b0;
      pin_in = 48'h3C00000000A7;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_mode_ab();
      t_mode_c();
      t_ignored_bits();
      t_data_write();
      t_map();
      t_bit_cmd();
      t_read_mix();
      t_ctrl_read();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule